// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the core's side of one coprocessor instruction from start to finish. A start strobe delivers the instruction class, a coprocessor number, a base address and a writeback bit. The sequencer checks whether that coprocessor may be used, then queries it. It keeps polling while the coprocessor reports busy, and during that wait it gives up on the instruction if an interrupt becomes pending.

If the coprocessor accepts, the sequencer finishes the instruction. For memory transfers it moves words between a simple word memory port and the coprocessor, stepping the address by one word for as long as the coprocessor asks for more. For register moves it spends the fixed cycles needed to pass the value across. For data operations it simply completes. When the coprocessor refuses, the sequencer raises an undefined-instruction or abort exception. Only one instruction is handled at a time.

Instruction classes on `cp_op`: 0 load to coprocessor, 1 store from coprocessor, 2 move core to coprocessor, 3 move coprocessor to core, 4 to 7 data operation. Phase codes on `cp_phase`: 0 none, 1 first query, 2 repeated query, 3 interrupted, 4 transfer, 5 data.

Top module: `cop_handshake_seq`

## Requirements
- R1: When `cp_allow[cp_num]` is 0 at start, `undef_exc` pulses in the first cycle after the start edge and `cp_phase` never leaves 0.
- R2: The first query shows phase 1. Each busy answer costs one cycle with phase 0, followed by a repeated query with phase 2.
- R3: If an interrupt is pending in the idle cycle after a busy answer, the next cycle shows phase 3 with an `abandon` pulse, and the instruction ends.
- R4: Interrupt source priority: `rst_req_n` low gives `int_src` 1, else unmasked `fiq` gives 2, else unmasked `irq` gives 3. A source whose mask is 1 is not pending. `int_src` is 0 outside phase 3.
- R5: A refusal (`cp_cant` without `cp_busy`) ends a load or store with `abort_exc` and any other class with `undef_exc`, in the cycle after the query. A refused class-3 move sets `result` to `{flags, 0}`, with the flags in the top four bits.
- R6: A load shows phase 4 for one cycle and then phase 5. In each phase-5 cycle it reads `mem_addr` = base + 4·i and presents the word on `cp_rdata`. It keeps going while `cp_inc` is 1, so it makes one read more than the number of increments.
- R7: A store uses the same address sequence and writes `cp_wdata` to memory during each phase-5 cycle.
- R8: `wb_req` pulses during the phase-4 cycle, and only when the `wb_bit` latched at start is 1.
- R9: A store whose base address has bits above bit 25 set, or lies below 32, ends with `abort_exc` in the first cycle after start, with no phase.
- R10: With no busy answers, `done` comes 2 cycles after start for a data operation, 3 for a core-to-coprocessor move (the value is on `cp_rdata` in its phase-5 cycle), and 4 for a coprocessor-to-core move, whose `result` is the `cp_wdata` of its phase-5 cycle. Each busy answer adds 2 cycles.
- R11: A start strobe while an instruction is in flight is ignored. After any end pulse, the next cycle is idle.
- R12: After reset, the phase is 0 and no end pulse, memory strobe or writeback request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Instruction start strobe |
| cp_op | input | 3 | Instruction class |
| cp_num | input | 4 | Coprocessor number |
| base_addr | input | 32 | First word address |
| wb_bit | input | 1 | Base writeback requested by instruction |
| core_data | input | 32 | Core register value for core-to-coprocessor move |
| flags | input | 4 | Current condition flags |
| cp_allow | input | 16 | Per-coprocessor access permission |
| cp_phase | output | 3 | Phase signalled to coprocessor |
| cp_busy | input | 1 | Coprocessor busy answer |
| cp_cant | input | 1 | Coprocessor refusal |
| cp_inc | input | 1 | Coprocessor wants another word |
| cp_wdata | input | 32 | Word from coprocessor |
| cp_rdata | output | 32 | Word to coprocessor |
| mem_addr | output | 32 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational |
| rst_req_n | input | 1 | Pending reset request, active low |
| fiq | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt mask |
| irq | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt mask |
| done | output | 1 | Instruction completed |
| undef_exc | output | 1 | Undefined-instruction exception |
| abort_exc | output | 1 | Abort exception |
| abandon | output | 1 | Instruction abandoned for interrupt |
| int_src | output | 2 | Winning interrupt source on abandon |
| wb_req | output | 1 | Base writeback request |
| result | output | 32 | Move-to-core result |

## Verification
The assertions assume that the coprocessor answers in the same cycle as the phase it sees. They also assume that `cp_inc` only means something in phase 5 and that busy outranks refusal. The bench's coprocessor model follows these rules: it drives its answers on the falling edge from the phase just observed. It holds busy for a set number of queries, and it answers increment only in phase 5. Interrupt inputs and permissions stay steady during each instruction. Memory returns the address XOR a fixed key, so every load word can be checked arithmetically.

// File: rtl/cop_handshake_seq.sv
`timescale 1ns/1ps
module cop_handshake_seq #(
  parameter int AW = 32,
  parameter int CPN = 16,
  parameter int ADDR_SPAN = 26,
  parameter int VEC_TOP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cp_op,
  input  logic [$clog2(CPN)-1:0] cp_num,
  input  logic [AW-1:0]     base_addr,
  input  logic              wb_bit,
  input  logic [AW-1:0]     core_data,
  input  logic [3:0]        flags,
  input  logic [CPN-1:0]    cp_allow,
  output logic [2:0]        cp_phase,
  input  logic              cp_busy,
  input  logic              cp_cant,
  input  logic              cp_inc,
  input  logic [AW-1:0]     cp_wdata,
  output logic [AW-1:0]     cp_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_wdata,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              rst_req_n,
  input  logic              fiq,
  input  logic              fiq_mask,
  input  logic              irq,
  input  logic              irq_mask,
  output logic              done,
  output logic              undef_exc,
  output logic              abort_exc,
  output logic              abandon,
  output logic [1:0]        int_src,
  output logic              wb_req,
  output logic [AW-1:0]     result
);
  localparam logic [AW-1:0] STEP = AW'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_QUERY, S_WAIT, S_INTR, S_XFER, S_DATA,
    S_CCYC, S_ICYC, S_DONE, S_UNDEF, S_ABORT
  } st_t;

  st_t st, nxt;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q, res_q;
  logic          wb_q, again_q;
  logic [1:0]    src_q;

  wire ldst     = (op_q[2:1] == 2'b00);
  wire from_cp  = (op_q == 3'd3);
  wire to_cp    = (op_q == 3'd2);
  wire fiq_live = fiq & ~fiq_mask;
  wire irq_live = irq & ~irq_mask;
  wire int_pend = ~rst_req_n | fiq_live | irq_live;
  wire bad_st   = (|base_addr[AW-1:ADDR_SPAN]) || (base_addr < AW'(VEC_TOP));

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:
        if (start)
          nxt = !cp_allow[cp_num] ? S_UNDEF :
                (cp_op == 3'd1 && bad_st) ? S_ABORT : S_QUERY;
      S_QUERY:
        if (cp_busy)      nxt = S_WAIT;
        else if (cp_cant) nxt = ldst ? S_ABORT : S_UNDEF;
        else if (ldst)    nxt = S_XFER;
        else if (op_q[2]) nxt = S_DONE;
        else              nxt = S_CCYC;
      S_WAIT: nxt = int_pend ? S_INTR : S_QUERY;
      S_XFER: nxt = S_DATA;
      S_DATA: if (!cp_inc) nxt = S_DONE;
      S_CCYC: nxt = from_cp ? S_ICYC : S_DONE;
      S_ICYC: nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0;
      addr_q <= '0;
      res_q <= '0;
      wb_q <= 1'b0;
      again_q <= 1'b0;
      src_q <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) begin
        op_q <= cp_op;
        addr_q <= base_addr;
        wb_q <= wb_bit;
        again_q <= 1'b0;
      end
      if (st == S_QUERY && cp_busy) again_q <= 1'b1;
      if (st == S_QUERY && !cp_busy && cp_cant && from_cp)
        res_q <= {flags, {(AW-4){1'b0}}};
      if (st == S_WAIT)
        src_q <= !rst_req_n ? 2'd1 : fiq_live ? 2'd2 : 2'd3;
      if (st == S_DATA && cp_inc) addr_q <= addr_q + STEP;
      if (st == S_CCYC && from_cp) res_q <= cp_wdata;
    end
  end

  assign cp_phase = (st == S_QUERY) ? (again_q ? 3'd2 : 3'd1) :
                    (st == S_INTR)  ? 3'd3 :
                    (st == S_XFER)  ? 3'd4 :
                    (st == S_DATA || st == S_CCYC) ? 3'd5 : 3'd0;
  assign mem_addr  = addr_q;
  assign mem_rd    = (st == S_DATA) && (op_q == 3'd0);
  assign mem_wr    = (st == S_DATA) && (op_q == 3'd1);
  assign mem_wdata = cp_wdata;
  assign cp_rdata  = mem_rd ? mem_rdata :
                     (st == S_CCYC && to_cp) ? core_data : '0;
  assign wb_req    = (st == S_XFER) && wb_q;
  assign done      = (st == S_DONE);
  assign undef_exc = (st == S_UNDEF);
  assign abort_exc = (st == S_ABORT);
  assign abandon   = (st == S_INTR);
  assign int_src   = abandon ? src_q : 2'd0;
  assign result    = res_q;

  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase inside {3'd1, 3'd2} && cp_busy) |=> (cp_phase == 3'd0)); // R2
  AST_INTR_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == 3'd3) |-> (abandon && int_src != 2'd0)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == 3'd5 && cp_inc && (mem_rd || mem_wr)) |=> (mem_addr == $past(mem_addr) + STEP)); // R6
  AST_WR_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (cp_phase == 3'd5 && !mem_rd)); // R7
  AST_WB_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (cp_phase == 3'd4)); // R8
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || undef_exc || abort_exc || abandon) |=>
    (cp_phase == 3'd0 && !done && !undef_exc && !abort_exc && !abandon)); // R11
endmodule

// File: tb/test_cop_handshake_seq.sv
`timescale 1ns/1ps
module test_cop_handshake_seq;
  localparam logic [31:0] KEY = 32'hA5A5_0000;
  localparam logic [31:0] CPW = 32'hC0DE_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wb_bit = 0;
  logic [2:0] cp_op = 0;
  logic [3:0] cp_num = 0, flags = 4'b1010;
  logic [31:0] base_addr = 0, core_data = 32'h1234_5678, cp_wdata = 0;
  logic [15:0] cp_allow = 16'hFFFE;
  logic cp_busy = 0, cp_cant = 0, cp_inc = 0;
  logic rst_req_n = 1, fiq = 0, fiq_mask = 0, irq = 0, irq_mask = 0;
  logic [2:0] cp_phase;
  logic [31:0] cp_rdata, mem_addr, mem_wdata, mem_rdata, result;
  logic mem_rd, mem_wr, done, undef_exc, abort_exc, abandon, wb_req;
  logic [1:0] int_src;

  assign mem_rdata = mem_addr ^ KEY;
  always #2.5 clk = ~clk;

  cop_handshake_seq i_cop_handshake_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cp_op(cp_op), .cp_num(cp_num),
    .base_addr(base_addr), .wb_bit(wb_bit), .core_data(core_data), .flags(flags),
    .cp_allow(cp_allow), .cp_phase(cp_phase), .cp_busy(cp_busy), .cp_cant(cp_cant),
    .cp_inc(cp_inc), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rst_req_n(rst_req_n), .fiq(fiq), .fiq_mask(fiq_mask), .irq(irq),
    .irq_mask(irq_mask), .done(done), .undef_exc(undef_exc), .abort_exc(abort_exc),
    .abandon(abandon), .int_src(int_src), .wb_req(wb_req), .result(result));

  int n_chk = 0, n_fail = 0;
  int n_first, n_busyq, n_idle, n_phase, n_xfer, n_data, n_wb;
  int end_kind, end_cyc, src_seen, addr_err, data_err, after_busy;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [3:0] num, input logic [31:0] addr,
                     input logic wb, input int nb, input logic cantm, input int ninc,
                     input bit poke);
    int busy_left = nb;
    int inc_left = ninc;
    int idx = 0;
    logic [31:0] ea;
    n_first = 0; n_busyq = 0; n_idle = 0; n_phase = 0; n_xfer = 0; n_data = 0;
    n_wb = 0; end_kind = 0; end_cyc = 0; src_seen = 0; addr_err = 0; data_err = 0;
    @(negedge clk);
    start = 1; cp_op = op; cp_num = num; base_addr = addr; wb_bit = wb;
    @(negedge clk);
    start = 0;
    for (int c = 1; c <= 60; c++) begin
      start = poke && (c == 2);
      if (poke && c == 2) begin cp_op = 3'd4; cp_num = 4'd0; end
      cp_busy = 0; cp_cant = 0; cp_inc = 0; cp_wdata = CPW + idx;
      if (cp_phase == 3'd1 || cp_phase == 3'd2) begin
        if (busy_left > 0) begin cp_busy = 1; busy_left--; end
        else cp_cant = cantm;
      end
      if (cp_phase == 3'd5 && inc_left > 0) begin cp_inc = 1; inc_left--; end
      #1;
      if (cp_phase != 0) n_phase++;
      if (cp_phase == 3'd1) n_first++;
      if (cp_phase == 3'd2) n_busyq++;
      if (cp_phase == 3'd4) n_xfer++;
      if (cp_phase == 3'd0 && !(done | undef_exc | abort_exc | abandon)) n_idle++;
      if (wb_req) n_wb++;
      if (cp_phase == 3'd5) begin
        n_data++;
        ea = addr + 32'(4 * idx);
        if (op == 3'd0 || op == 3'd1) begin
          if (mem_addr !== ea) addr_err++;
          if (op == 3'd0 && (!mem_rd || cp_rdata !== (ea ^ KEY))) data_err++;
          if (op == 3'd1 && (!mem_wr || mem_wdata !== CPW + idx)) data_err++;
        end
        if (op == 3'd2 && cp_rdata !== core_data) data_err++;
        idx++;
      end
      if (done | undef_exc | abort_exc | abandon) begin
        end_kind = done ? 1 : undef_exc ? 2 : abort_exc ? 3 : 4;
        end_cyc = c;
        src_seen = int_src;
        break;
      end
      @(negedge clk);
    end
    start = 0; cp_busy = 0; cp_cant = 0; cp_inc = 0;
    after_busy = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (cp_phase != 0 || done || undef_exc || abort_exc || abandon) after_busy++;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cp_phase == 0 && !done && !undef_exc && !abort_exc && !abandon &&
        !mem_rd && !mem_wr && !wb_req, "R12 reset state", cp_phase, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cp_phase == 0 && !done && !mem_wr, "R12 idle after reset", cp_phase, 0);

    run(3'd4, 4'd0, 32'h100, 0, 0, 0, 0, 0);
    chk(end_kind == 2 && end_cyc == 1, "R1 denied end", end_kind * 100 + end_cyc, 201);
    chk(n_phase == 0, "R1 no phase", n_phase, 0);

    for (int nb = 0; nb < 4; nb++) begin
      run(3'd4, 4'd5, 32'h100, 0, nb, 0, 0, 0);
      chk(end_kind == 1 && end_cyc == 2 + 2 * nb, "R10 data op latency", end_cyc, 2 + 2 * nb);
      chk(n_first == 1 && n_busyq == nb, "R2 query phases", n_busyq, nb);
      chk(n_idle == nb, "R2 idle per busy", n_idle, nb);
    end

    for (int nb = 0; nb < 2; nb++) begin
      run(3'd2, 4'd5, 32'h100, 0, nb, 0, 0, 0);
      chk(end_kind == 1 && end_cyc == 3 + 2 * nb, "R10 move to cp latency", end_cyc, 3 + 2 * nb);
      chk(n_data == 1 && data_err == 0, "R10 move to cp value", data_err, 0);
      run(3'd3, 4'd5, 32'h100, 0, nb, 0, 0, 0);
      chk(end_kind == 1 && end_cyc == 4 + 2 * nb, "R10 move to core latency", end_cyc, 4 + 2 * nb);
      chk(result == CPW, "R10 move to core result", result, CPW);
    end

    for (int op = 0; op < 5; op++) begin
      run(3'(op), 4'd7, 32'h200, 0, 1, 1, 0, 0);
      chk(end_kind == (op < 2 ? 3 : 2) && end_cyc == 4, "R5 refusal path",
          end_kind, op < 2 ? 3 : 2);
      if (op == 3) chk(result == 32'hA000_0000, "R5 refused move flags", result, 32'hA000_0000);
    end

    for (int ni = 0; ni < 4; ni++) begin
      for (int wb = 0; wb < 2; wb++) begin
        run(3'd0, 4'd3, 32'h1000 + 32'(ni * 64), wb[0], 1, 0, ni, 0);
        chk(end_kind == 1 && end_cyc == 6 + ni, "R6 load end", end_cyc, 6 + ni);
        chk(n_xfer == 1 && n_data == ni + 1 && addr_err == 0 && data_err == 0,
            "R6 load words", n_data * 1000 + addr_err + data_err, (ni + 1) * 1000);
        chk(n_wb == wb, "R8 writeback request", n_wb, wb);
      end
      run(3'd1, 4'd9, 32'h0200_0000 + 32'(ni * 16), 0, 0, 0, ni, 0);
      chk(end_kind == 1 && n_data == ni + 1 && addr_err == 0 && data_err == 0,
          "R7 store words", n_data * 1000 + addr_err + data_err, (ni + 1) * 1000);
      chk(n_wb == 0, "R8 no writeback", n_wb, 0);
    end

    run(3'd1, 4'd5, 32'h10, 0, 0, 0, 0, 0);
    chk(end_kind == 3 && end_cyc == 1 && n_phase == 0, "R9 vector store", end_kind, 3);
    run(3'd1, 4'd5, 32'h0400_0000, 0, 0, 0, 0, 0);
    chk(end_kind == 3 && end_cyc == 1 && n_phase == 0, "R9 high store", end_kind, 3);
    run(3'd0, 4'd5, 32'h10, 0, 0, 0, 0, 0);
    chk(end_kind == 1, "R9 load not aborted", end_kind, 1);

    for (int v = 0; v < 32; v++) begin
      int exp_src;
      rst_req_n = ~v[0]; fiq = v[1]; fiq_mask = v[2]; irq = v[3]; irq_mask = v[4];
      exp_src = v[0] ? 1 : (v[1] && !v[2]) ? 2 : (v[3] && !v[4]) ? 3 : 0;
      run(3'd4, 4'd5, 32'h100, 0, 2, 0, 0, 0);
      if (exp_src != 0) begin
        chk(end_kind == 4 && end_cyc == 3, "R3 abandon", end_kind * 100 + end_cyc, 403);
        chk(src_seen == exp_src, "R4 interrupt priority", src_seen, exp_src);
      end else begin
        chk(end_kind == 1 && end_cyc == 6, "R4 masked ignored", end_kind * 100 + end_cyc, 106);
      end
    end
    rst_req_n = 1; fiq = 0; fiq_mask = 0; irq = 0; irq_mask = 0;

    run(3'd4, 4'd5, 32'h100, 0, 1, 0, 0, 1);
    chk(end_kind == 1 && end_cyc == 4, "R11 start ignored", end_kind * 100 + end_cyc, 104);
    chk(after_busy == 0, "R11 idle after end", after_busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule